// File: doc/BRIEF.md
# Two-Line Interrupt Status Aggregator

This block gathers a vector of single-cycle event pulses into a sticky status register, gates each flag with its own enable bit, and steers every source to one of two interrupt output lines. Each line has its own master gate. Software reaches the four registers through a plain word-addressed write port with a combinational read path. It clears pending flags by writing back the status value it read, since a 1 written to a status bit clears that bit.

An event always records into status, whatever the enable bit holds, so a driver can poll with interrupts masked. Closing both line gates silences the outputs and keeps every pending flag. When a pulse and a clear hit the same bit in the same cycle, the pulse wins and the event is not lost.

Top module: `evt_irq_steer`

## Requirements
- R1: After reset, all four registers read zero and both interrupt lines are low.
- R2: A pulse on source bit i sets status bit i at the next clock edge, whether or not enable bit i is set, and the bit stays set until it is cleared (status is at address 0).
- R3: A write to address 0 clears each status bit where the written data holds a 1 and leaves the bits written 0 unchanged.
- R4: If a source pulse and a clearing write to the same status bit fall in the same cycle, the bit is set after that edge.
- R5: The enable register at address 1 reads back as written, and a status bit whose enable bit is 0 drives neither line.
- R6: The line-select register at address 2 reads back as written; select bit i equal to 0 routes source i to line 0 (irq[0]), and 1 routes it to irq[1].
- R7: The line-enable register at address 3 holds two bits, bit 0 gating irq[0] and bit 1 gating irq[1], and its upper bits read zero; with both bits at 0 both lines are low and status keeps its contents.
- R8: irq[n] is high exactly when line-enable bit n is set and some bit i has status, enable and routing to line n all true, updating in the cycle after the register change.
- R9: Writes to addresses above 3 change no register, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NSRC | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for both read and write |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data for the register at addr |
| irq | output | 2 | Interrupt lines 0 and 1 |

## Verification
The bench uses the defaults of 32 sources and a 4-bit address. With those, the split that puts the upper sixteen sources on line 1 can be exercised directly, and unmapped addresses 4 to 15 can be probed. A behavioural model tracks all registers and both lines through directed phases and a long pseudo-random run. In that run, pulses, clears and gate changes fall together in the same cycle, which reaches the set-over-clear collision on many bits at once.

// File: rtl/evt_irq_steer.sv
module evt_irq_steer #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic [1:0]        irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(3);

  logic [NSRC-1:0] st_q, en_q, sel_q;
  logic [1:0]      le_q;
  logic [NSRC-1:0] clr, pend0, pend1;

  assign clr = (wr_en && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      sel_q <= '0;
      le_q  <= '0;
    end else begin
      st_q <= (st_q & ~clr) | evt;
      if (wr_en) begin
        case (addr)
          A_EN:    en_q  <= wdata;
          A_SEL:   sel_q <= wdata;
          A_LEN:   le_q  <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign pend0 = st_q & en_q & ~sel_q;
  assign pend1 = st_q & en_q & sel_q;
  assign irq   = le_q & {|pend1, |pend0};

  always_comb begin
    case (addr)
      A_STAT:  rdata = st_q;
      A_EN:    rdata = en_q;
      A_SEL:   rdata = sel_q;
      A_LEN:   rdata = {{(NSRC-2){1'b0}}, le_q};
      default: rdata = '0;
    endcase
  end
endmodule

module evt_irq_steer_chk #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   st,
  input logic [NSRC-1:0]   en,
  input logic [1:0]        le,
  input logic [1:0]        irq
);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == '0) |=> ((st & $past(st)) == $past(st)));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((st & $past(evt)) == $past(evt)));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && evt == '0) |=> ((st & $past(wdata)) == '0));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (le == 2'b00) |-> (irq == 2'b00));

  a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & en) == '0) |-> (irq == 2'b00));
endmodule

bind evt_irq_steer evt_irq_steer_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .st(st_q), .en(en_q), .le(le_q), .irq(irq)
);

// File: tb/evt_irq_steer_tb.sv
module evt_irq_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] evt = '0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [NSRC-1:0] rdata;
  logic [1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_st = 0, m_en = 0, m_sel = 0;
  logic [1:0]  m_le = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_steer #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] m_read(input logic [ADDR_W-1:0] a);
    case (a)
      0: return m_st;
      1: return m_en;
      2: return m_sel;
      3: return {30'b0, m_le};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [1:0] m_irq();
    logic [1:0] r;
    r[0] = m_le[0] && ((m_st & m_en & ~m_sel) != 0);
    r[1] = m_le[1] && ((m_st & m_en & m_sel) != 0);
    return r;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (rdata !== m_read(addr)) begin
      n_bad++;
      $display("FAIL %s rdata addr %0d: actual %h expected %h", tag, addr, rdata, m_read(addr));
    end
    n_cmp++;
    if (irq !== m_irq()) begin
      n_bad++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, m_irq());
    end
  endtask

  task automatic step(input logic w, input logic [ADDR_W-1:0] a,
                      input logic [31:0] d, input logic [31:0] e, input string tag);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt = e;
    @(posedge clk);
    if (w && a == 0) m_st = m_st & ~d;
    m_st = m_st | e;
    if (w && a == 1) m_en = d;
    if (w && a == 2) m_sel = d;
    if (w && a == 3) m_le = d[1:0];
    #1;
    evt = '0; wr_en = 1'b0;
    #1;
    compare(tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    step(1'b0, a, 32'h0, 32'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) rd(ADDR_W'(a), "R1");

    // R2 events record with enable 0, stay sticky
    step(1'b0, 0, 0, 32'h0000_0209, "R2");
    rd(0, "R2");
    step(1'b0, 0, 0, 32'h8200_0000, "R2");
    rd(0, "R2");

    // R5 enable readback and masking
    step(1'b1, 1, 32'h0000_0001, 0, "R5");
    rd(1, "R5");
    step(1'b1, 3, 32'h3, 0, "R5");   // line gates on; only bit0 enabled
    rd(0, "R5");

    // R6 routing: upper half to line 1
    step(1'b1, 2, 32'hFFFF_0000, 0, "R6");
    rd(2, "R6");
    step(1'b1, 1, 32'h8000_0000, 0, "R6");   // only bit31 -> irq[1]
    rd(0, "R6");
    step(1'b1, 1, 32'hFFFF_FFFF, 0, "R8");
    rd(3, "R7");

    // R7 gates off: lines low, status kept
    step(1'b1, 3, 32'hFFFF_FFFC, 0, "R7");
    rd(3, "R7");
    rd(0, "R7");
    step(1'b1, 3, 32'hFFFF_FFFE, 0, "R7");   // only line 1
    rd(0, "R7");

    // R3 partial write-one-to-clear
    step(1'b1, 0, 32'h0000_0201, 0, "R3");
    rd(0, "R3");
    step(1'b1, 3, 32'h3, 0, "R8");
    step(1'b1, 0, 32'hFFFF_FFFF, 0, "R3");
    rd(0, "R3");

    // R4 set wins over clear
    step(1'b1, 0, 32'h0000_0010, 32'h0000_0010, "R4");
    rd(0, "R4");
    step(1'b1, 0, 32'hF000_0000, 32'h1000_0001, "R4");
    rd(0, "R4");

    // R9 unmapped addresses
    step(1'b1, 4, 32'hDEAD_BEEF, 0, "R9");
    step(1'b1, 15, 32'h1234_5678, 0, "R9");
    for (int a = 0; a < 16; a++) rd(ADDR_W'(a), "R9");

    // R8 pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev, dt;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      dt = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      ev = (lfsr[3:0] == 4'h0) ? (dt & {lfsr[7:0], lfsr[31:8]}) : 32'h0;
      step(lfsr[9], ADDR_W'(lfsr[14:12] & 3'(lfsr[15] ? 7 : 3)), dt, ev, "R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule